// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Guard

This block sits between a processor's active-low memory chip-enable and a battery-backed RAM. While the supply is healthy the chip-enable travels through a purely combinational path, so the memory sees each edge with no added register stage. When the supervisor raises its reset request, the guard keeps the path open for a programmable number of clock cycles, so that a write cycle already under way can finish. It then shuts the path and holds the memory deselected by forcing the output high.

Once shut, the guard stays shut for as long as the reset request is high, whatever the chip-enable input does. It reopens on the first clock edge at which the request is seen low. If the request drops before the hold-off window has run out, the window is abandoned, the path never closes, and a later request starts a full window again. After a power-on reset the guard starts out shut.

The chip-enable is a level, not a stream of data words, so there is nothing to hold back and the block has no valid/ready handshake. All pins are plain control and status pins. The reset request must be synchronous to `clk`.

Top module: `ce_guard`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `gate_open` is 0 and `ce_out_n` is 1.
- R2: While `gate_open` is 1, `ce_out_n` equals `ce_in_n` in the same cycle, with no clock edge in the path.
- R3: While `gate_open` is 0, `ce_out_n` is 1 whatever the value of `ce_in_n`.
- R4: A clock edge that samples `rst_req` low leaves `gate_open` at 1 after that edge, from any prior state.
- R5: If `rst_req` is first sampled high at edge k while the gate is open and stays high, `gate_open` remains 1 after edges k to k+HOLD_CYCLES-1 and becomes 0 after edge k+HOLD_CYCLES.
- R6: If `rst_req` is sampled low at any edge inside that window, the gate never closes, and the next high sample starts a full HOLD_CYCLES window again.
- R7: While the gate is shut and `rst_req` stays high, `gate_open` stays 0, however `ce_in_n` toggles.
- R8: `gate_open` changes only at rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Reset request from the supply supervisor, active high, synchronous to clk |
| ce_in_n | input | 1 | Chip-enable from the processor, active low |
| ce_out_n | output | 1 | Chip-enable to the memory, active low |
| gate_open | output | 1 | 1 while the chip-enable path is open |

## Verification
A wrong gate state appears at the ports within the same cycle. `gate_open` takes the wrong value after the faulty edge, and `ce_out_n` either stops following `ce_in_n` or leaks a low level while the memory should be deselected. A hold-off counter that is off by one moves the closing edge by exactly one cycle. A timer that is not cancelled closes the gate even though the request was withdrawn. A timer that is not cleared between requests shortens the next window. Comparing both outputs against a reference model on every cycle, with `ce_in_n` toggled in each phase, catches each of these faults within one clock.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;
  typedef enum logic [1:0] {
    GATE_SHUT  = 2'd0,
    GATE_OPEN  = 2'd1,
    GATE_DRAIN = 2'd2
  } gate_state_t;
endpackage

// File: rtl/ce_guard_holdoff.sv
module ce_guard_holdoff #(
  parameter int HOLD_CYCLES = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (!expired)   cnt <= cnt + 1'b1;
  end

  // window length for R5
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expired) |=> (!run || (cnt == CW'($past(cnt) + 1'b1))));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // restart from zero for R6
  p_count_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/ce_guard_fsm.sv
module ce_guard_fsm
  import ce_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  logic expired,
  output logic run,
  output logic gate_open
);
  gate_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      GATE_SHUT:  if (!rst_req) state_nx = GATE_OPEN;
      GATE_OPEN:  if (rst_req)  state_nx = GATE_DRAIN;
      GATE_DRAIN: begin
        if (!rst_req)     state_nx = GATE_OPEN;
        else if (expired) state_nx = GATE_SHUT;
      end
      default:            state_nx = GATE_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= GATE_SHUT;
    else        state <= state_nx;
  end

  assign run       = (state == GATE_DRAIN);
  assign gate_open = (state != GATE_SHUT);

  p_release_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |=> gate_open);
  p_close_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && rst_req) |=> !gate_open);
  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rst_req) |=> (gate_open && !run));
  p_stay_shut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && rst_req) |=> !gate_open);
endmodule

// File: rtl/ce_guard.sv
module ce_guard #(
  parameter int HOLD_CYCLES = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_req,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic gate_open
);
  logic run;
  logic expired;

  ce_guard_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_holdoff (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .expired (expired)
  );

  ce_guard_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req   (rst_req),
    .expired   (expired),
    .run       (run),
    .gate_open (gate_open)
  );

  assign ce_out_n = gate_open ? ce_in_n : 1'b1;

  initial begin
    a_hold_min_r5: assert (HOLD_CYCLES >= 1);
  end

  p_drain_opened_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(gate_open));
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (!gate_open && ce_out_n));
endmodule

// File: tb/ce_guard_tb.sv
`timescale 1ns/1ps
module ce_guard_tb;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b1;
  logic ce_in_n = 1'b1;
  logic ce_out_n;
  logic gate_open;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string tag = "R1";

  bit m_open = 0;
  int m_high = 0;

  always #10 clk = ~clk;

  ce_guard #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
    .ce_in_n(ce_in_n), .ce_out_n(ce_out_n), .gate_open(gate_open)
  );

  // reference model: edges seen with the request high while the gate is open
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_high = 0;
    end else if (!rst_req) begin
      m_open = 1; m_high = 0;
    end else if (m_open) begin
      m_high = m_high + 1;
      if (m_high > HOLD) m_open = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    check(tag, gate_open, m_open);
    check(m_open ? "R2" : "R3", ce_out_n, m_open ? ce_in_n : 1'b1);
  endtask

  // per-cycle comparison away from the edge, plus registered-output check (R8)
  logic held;
  always @(posedge clk) begin
    #5;
    check_outs();
    held = gate_open;
    #9;
    check_outs();
    check("R8", gate_open, held);
  end

  task automatic step(input logic req, input logic ce);
    @(posedge clk);
    #12;
    rst_req = req;
    ce_in_n = ce;
  endtask

  initial begin
    #5;
    check("R1", gate_open, 1'b0);
    check("R1", ce_out_n, 1'b1);
    ce_in_n = 1'b0;
    #1;
    check("R1", ce_out_n, 1'b1);
    #60;
    rst_n = 1'b1;
    // power-up: request still high, input toggling
    tag = "R7";
    for (int i = 0; i < 8; i++) step(1'b1, i[0]);
    // release
    tag = "R4";
    step(1'b0, 1'b1);
    tag = "R2";
    for (int i = 0; i < 6; i++) step(1'b0, ~i[0]);
    // request held: close after HOLD cycles
    tag = "R5";
    for (int i = 0; i < HOLD + 4; i++) step(1'b1, i[0]);
    tag = "R7";
    for (int i = 0; i < 6; i++) step(1'b1, ~i[0]);
    tag = "R4";
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    // cancelled window, then full window must restart
    tag = "R6";
    for (int i = 0; i < HOLD - 1; i++) step(1'b1, i[0]);
    step(1'b0, 1'b0);
    for (int i = 0; i < HOLD + 3; i++) step(1'b1, ~i[0]);
    step(1'b0, 1'b1);
    // single-cycle pulses
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
    end
    tag = "R2";
    for (int i = 0; i < 4; i++) step(1'b0, i[0]);
    @(posedge clk); #16;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule